// File: doc/BRIEF.md
# GPIO Pad Configuration Register Bank

This block is a memory-mapped register bank that holds one 13-bit configuration word for each of 38 general-purpose pads, numbered 0 to 37. Software writes these words over a simple single-cycle slave port in the Wishbone style. The pads do not see a new word when it is written. Software makes the words take effect by writing a 1 to the transfer register.

On that write the block takes a snapshot of all configuration words. It shifts the snapshot out on a serial chain, one bit per cycle, and then pulses a load strobe so that every pad latches its new setting at the same moment. The transfer register reads back 1 while the shift is running and clears itself when the shift ends.

The bank also holds the output data for the pads. One register covers pads 0 to 31 and a second covers pads 32 to 37. These two registers drive the pad data outputs as soon as they are written. Bit 0 of a configuration word selects the owner of the pad: 1 gives it to the management side and 0 gives it to the user side. The usual encodings are 0x1809 for a management standard output and 0x1808 for a user standard output.

Top module: `gcb_top`

## Requirements
- R1: After reset, every register reads 0, `pad_data` is 0, and `chain_shift`, `chain_data` and `chain_load` are all 0.
- R2: An access is acknowledged in the cycle after `bus_cyc` and `bus_stb` are both high. `bus_ack` stays high for exactly one cycle. Read data is valid while `bus_ack` is high.
- R3: Pad n has its configuration register at byte offset 0x24 + 4*n, for n from 0 to 37. The register stores bits 12:0 of the write data and reads back with bits 31:13 equal to 0. Examples are 0x1809 (management output, bit 0 = 1) and 0x1808 (user output, bit 0 = 0).
- R4: A write to offset 0x0C loads a 32-bit register that drives `pad_data[31:0]`. A write to offset 0x10 stores bits 5:0, which drive `pad_data[37:32]`. Both take effect in the cycle in which the write is acknowledged, and both read back what was stored.
- R5: A read at an offset that is unmapped or misaligned returns 0. A write to such an offset changes no register and starts no transfer.
- R6: Writing a value with bit 0 = 1 to offset 0x00 starts a transfer. Offset 0x00 reads 1 while the transfer runs and 0 once it has ended.
- R7: A transfer raises `chain_shift` for exactly 38*13 = 494 consecutive cycles. In each of those cycles it drives one bit on `chain_data`: pad 37 first, and most significant bit first within each pad.
- R8: `chain_load` is high for exactly one cycle, the cycle that follows the last shift cycle.
- R9: A configuration write made during a transfer is stored and reads back at once. It does not change the bits of the transfer already running, and a later transfer sends the new value.
- R10: Writing 1 to offset 0x00 while a transfer is running neither restarts nor lengthens it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_adr | input | 8 | Byte offset inside the bank |
| bus_wdat | input | 32 | Write data |
| bus_rdat | output | 32 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | Access acknowledge |
| pad_data | output | 38 | Output data for pads 37..0 |
| chain_data | output | 1 | Serial configuration bit |
| chain_shift | output | 1 | Qualifies `chain_data` each cycle |
| chain_load | output | 1 | One-cycle latch strobe for every pad |

## Verification
The two faults that can do real harm here are a bit counter that is off by one and a snapshot taken at the wrong time. A counter that is off by one shows up in the same transfer as a shift window of 493 or 495 cycles, or as a `chain_load` pulse that is not next to the last bit. A snapshot taken at the wrong time shows up because the captured 494-bit stream no longer matches the words that were written before the start, in particular once the write to pad 5 during the transfer has been made. Faults in address decode show up one cycle after the access, through the read data and `pad_data`, both inside and outside the mapped offsets.

// File: rtl/gcb_pkg.sv
// Package gcb_pkg
// Shared constants for the pad configuration bank: byte offsets of the registers.
// Assumes a byte-addressed bank in which every register sits on a 32-bit word boundary.
package gcb_pkg;
    localparam int OFS_XFER = 'h00;
    localparam int OFS_DLO  = 'h0C;
    localparam int OFS_DHI  = 'h10;
    localparam int OFS_CFG0 = 'h24;
    localparam int DW       = 32;
endpackage

// File: rtl/gcb_bus_if.sv
// Module gcb_bus_if
// Turns cyc/stb into a one-cycle access pulse and a registered acknowledge.
// Assumes the master holds its request until it sees ack, then drops it.
module gcb_bus_if (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc,
    input  logic stb,
    output logic acc,
    output logic ack
);
    // Access pulse: a new request that has not been acknowledged yet
    assign acc = cyc & stb & ~ack;

    // Acknowledge register: high one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) ack <= 1'b0;
        else        ack <= acc;
    end
endmodule

// File: rtl/gcb_cfg_store.sv
// Module gcb_cfg_store
// One configuration register per pad, a read port, and a flattened view.
// The flattened view puts the highest pad in the top bits.
// Assumes wpad and rpad lie inside 0..NPADS-1 whenever they are used.
module gcb_cfg_store #(
    parameter int NPADS = 38,
    parameter int CFGW  = 13,
    localparam int PIW   = $clog2(NPADS),
    localparam int TOTAL = NPADS * CFGW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [PIW-1:0]   wpad,
    input  logic [CFGW-1:0]  wval,
    input  logic [PIW-1:0]   rpad,
    output logic [CFGW-1:0]  rval,
    output logic [TOTAL-1:0] flat
);
    logic [CFGW-1:0] cfg [NPADS];

    for (genvar p = 0; p < NPADS; p++) begin : g_pad
        // Configuration register of pad p
        always_ff @(posedge clk) begin
            if (!rst_n)                      cfg[p] <= '0;
            else if (wr && wpad == PIW'(p))  cfg[p] <= wval;
        end
        assign flat[p*CFGW +: CFGW] = cfg[p];
    end

    // Read select over all pads
    always_comb begin
        rval = '0;
        for (int p = 0; p < NPADS; p++)
            if (rpad == PIW'(p)) rval = cfg[p];
    end
endmodule

// File: rtl/gcb_shifter.sv
// Module gcb_shifter
// Takes a snapshot of all configuration words when start is pulsed and shifts it out
// MSB first, one bit per cycle, then pulses load for one cycle.
// A start while busy is ignored.
module gcb_shifter #(
    parameter int TOTAL = 494,
    localparam int CNTW = $clog2(TOTAL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TOTAL-1:0] flat,
    output logic             busy,
    output logic             ser_data,
    output logic             ser_shift,
    output logic             ser_load
);
    logic [TOTAL-1:0] shadow;
    logic [CNTW-1:0]  cnt;

    // Snapshot, shift and count sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow   <= '0;
            cnt      <= '0;
            busy     <= 1'b0;
            ser_load <= 1'b0;
        end else begin
            ser_load <= 1'b0;
            if (!busy && start) begin
                shadow <= flat;
                cnt    <= CNTW'(TOTAL);
                busy   <= 1'b1;
            end else if (busy) begin
                shadow <= shadow << 1;
                cnt    <= cnt - 1'b1;
                if (cnt == CNTW'(1)) begin
                    busy     <= 1'b0;
                    ser_load <= 1'b1;
                end
            end
        end
    end

    assign ser_shift = busy;
    assign ser_data  = busy & shadow[TOTAL-1];
endmodule

// File: rtl/gcb_top.sv
// Module gcb_top
// Pad configuration register bank: per-pad configuration words, a transfer
// register that pushes them to the pad chain, and the pad output data registers.
// Assumes 32 < NPADS <= 64 and an address space wide enough for every pad.
module gcb_top
    import gcb_pkg::*;
#(
    parameter int NPADS = 38,
    parameter int CFGW  = 13,
    parameter int AW    = 8,
    localparam int PIW   = $clog2(NPADS),
    localparam int HIW   = NPADS - 32,
    localparam int TOTAL = NPADS * CFGW,
    localparam int WIW   = AW - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_cyc,
    input  logic             bus_stb,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_adr,
    input  logic [DW-1:0]    bus_wdat,
    output logic [DW-1:0]    bus_rdat,
    output logic             bus_ack,
    output logic [NPADS-1:0] pad_data,
    output logic             chain_data,
    output logic             chain_shift,
    output logic             chain_load
);
    logic             acc, wr, busy, start;
    logic             aligned, is_xfer, is_dlo, is_dhi, is_cfg;
    logic [WIW-1:0]   word;
    logic [PIW-1:0]   pad_idx;
    logic [CFGW-1:0]  cfg_rval;
    logic [TOTAL-1:0] cfg_flat;
    logic [31:0]      dlo;
    logic [HIW-1:0]   dhi;
    logic [DW-1:0]    rsel;

    gcb_bus_if u_bus (
        .clk(clk), .rst_n(rst_n), .cyc(bus_cyc), .stb(bus_stb),
        .acc(acc), .ack(bus_ack)
    );

    // Address decode
    assign word    = bus_adr[AW-1:2];
    assign aligned = (bus_adr[1:0] == 2'b00);
    assign is_xfer = aligned && word == WIW'(OFS_XFER / 4);
    assign is_dlo  = aligned && word == WIW'(OFS_DLO / 4);
    assign is_dhi  = aligned && word == WIW'(OFS_DHI / 4);
    assign is_cfg  = aligned && word >= WIW'(OFS_CFG0 / 4)
                             && word <  WIW'(OFS_CFG0 / 4 + NPADS);
    assign pad_idx = PIW'(word - WIW'(OFS_CFG0 / 4));
    assign wr      = acc & bus_we;
    assign start   = wr & is_xfer & bus_wdat[0];

    gcb_cfg_store #(.NPADS(NPADS), .CFGW(CFGW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr(wr & is_cfg), .wpad(pad_idx),
        .wval(bus_wdat[CFGW-1:0]), .rpad(pad_idx), .rval(cfg_rval),
        .flat(cfg_flat)
    );

    gcb_shifter #(.TOTAL(TOTAL)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .flat(cfg_flat),
        .busy(busy), .ser_data(chain_data), .ser_shift(chain_shift),
        .ser_load(chain_load)
    );

    // Pad output data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlo <= '0;
            dhi <= '0;
        end else begin
            if (wr && is_dlo) dlo <= bus_wdat;
            if (wr && is_dhi) dhi <= bus_wdat[HIW-1:0];
        end
    end
    assign pad_data = {dhi, dlo};

    // Read data select
    always_comb begin
        rsel = '0;
        if (is_xfer)     rsel = DW'(busy);
        else if (is_dlo) rsel = dlo;
        else if (is_dhi) rsel = DW'(dhi);
        else if (is_cfg) rsel = DW'(cfg_rval);
    end

    // Registered read data, aligned with ack
    always_ff @(posedge clk) begin
        if (!rst_n)               bus_rdat <= '0;
        else if (acc && !bus_we)  bus_rdat <= rsel;
        else                      bus_rdat <= '0;
    end
endmodule

// File: rtl/gcb_chk.sv
// Module gcb_chk
// Protocol and transfer checks for gcb_top, attached with bind.
// Counts shift cycles with a counter, so the window length never becomes a $past depth.
module gcb_chk #(
    parameter int TOTAL = 494,
    localparam int RW = $clog2(TOTAL + 2)
) (
    input logic clk,
    input logic rst_n,
    input logic cyc,
    input logic stb,
    input logic ack,
    input logic shift,
    input logic load
);
    logic [RW-1:0] run;

    // Length of the current run of shift cycles
    always_ff @(posedge clk) begin
        if (!rst_n)     run <= '0;
        else if (shift) run <= run + 1'b1;
        else            run <= '0;
    end

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R2
    AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(cyc && stb)); // R2
    AST_SHIFT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift) |-> run == RW'(TOTAL)); // R7
    AST_LOAD_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift) |-> load); // R8
    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load); // R8
    AST_LOAD_NOT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !shift && $past(shift)); // R8
endmodule

bind gcb_top gcb_chk #(.TOTAL(NPADS * CFGW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cyc(bus_cyc), .stb(bus_stb),
    .ack(bus_ack), .shift(chain_shift), .load(chain_load)
);

// File: tb/test_gcb_top.sv
// Bench for gcb_top: a table of register vectors, then directed transfer tests.
module test_gcb_top;
    localparam int NPADS = 38;
    localparam int CFGW  = 13;
    localparam int TOTAL = NPADS * CFGW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_cyc = 0, bus_stb = 0, bus_we = 0;
    logic [7:0]  bus_adr = '0;
    logic [31:0] bus_wdat = '0;
    logic [31:0] bus_rdat;
    logic        bus_ack;
    logic [NPADS-1:0] pad_data;
    logic chain_data, chain_shift, chain_load;

    int total = 0, bad = 0, cycles = 0;
    logic ack_ok = 1'b1;

    gcb_top i_gcb_top (
        .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
        .bus_we(bus_we), .bus_adr(bus_adr), .bus_wdat(bus_wdat),
        .bus_rdat(bus_rdat), .bus_ack(bus_ack), .pad_data(pad_data),
        .chain_data(chain_data), .chain_shift(chain_shift), .chain_load(chain_load)
    );

    always #5 clk = ~clk;

    // Vector: {offset, write data, expected readback}
    localparam logic [71:0] VEC [9] = '{
        {8'h24, 32'h0000_1809, 32'h0000_1809},  // R3 pad 0, management output
        {8'hB8, 32'hFFFF_FFFF, 32'h0000_1FFF},  // R3 pad 37, upper bits dropped
        {8'h60, 32'h0000_1808, 32'h0000_1808},  // R3 pad 15, user output
        {8'hA0, 32'h0000_1809, 32'h0000_1809},  // R3 pad 31
        {8'h0C, 32'hA5A5_5A5A, 32'hA5A5_5A5A},  // R4 low data
        {8'h10, 32'hFFFF_FFFF, 32'h0000_003F},  // R4 high data
        {8'h04, 32'h0000_1234, 32'h0000_0000},  // R5 unmapped
        {8'hBC, 32'h0000_0077, 32'h0000_0000},  // R5 past last pad
        {8'h25, 32'h0000_0055, 32'h0000_0000}   // R5 misaligned
    };

    logic [CFGW-1:0]  exp_cfg [NPADS];
    logic [TOTAL-1:0] cap;
    int ncap = 0, nload = 0;
    logic load_pos_ok = 1'b1;
    logic prev_shift = 1'b0;

    // Serial stream capture, sampled away from the clock edge
    always @(negedge clk) begin
        if (chain_shift) begin
            cap  <= {cap[TOTAL-2:0], chain_data};
            ncap <= ncap + 1;
        end
        if (chain_load) begin
            nload <= nload + 1;
            if (!(prev_shift && !chain_shift)) load_pos_ok <= 1'b0;
        end
        prev_shift <= chain_shift;
    end

    task automatic chk(input logic ok, input string req, input logic [TOTAL-1:0] act,
                       input logic [TOTAL-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_acc(input logic we, input logic [7:0] a, input logic [31:0] d,
                           output logic [31:0] r);
        @(negedge clk);
        bus_cyc = 1; bus_stb = 1; bus_we = we; bus_adr = a; bus_wdat = d;
        @(negedge clk);
        if (bus_ack !== 1'b1) ack_ok = 1'b0;
        r = bus_rdat;
        bus_cyc = 0; bus_stb = 0; bus_we = 0;
        @(negedge clk);
        if (bus_ack !== 1'b0) ack_ok = 1'b0;
    endtask

    function automatic logic [TOTAL-1:0] exp_flat();
        logic [TOTAL-1:0] f;
        for (int p = 0; p < NPADS; p++) f[p*CFGW +: CFGW] = exp_cfg[p];
        return f;
    endfunction

    // Watchdog: a hung run is counted as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_xfer(input logic mid_write, output logic [TOTAL-1:0] snap);
        logic [31:0] r;
        snap = exp_flat();
        ncap = 0; nload = 0; load_pos_ok = 1'b1;
        bus_acc(1, 8'h00, 32'h1, r);
        bus_acc(0, 8'h00, 0, r);
        chk(r == 32'h1, "R6 busy reads 1", TOTAL'(r), TOTAL'(1));
        if (mid_write) begin
            bus_acc(1, 8'h38, 32'h0ABC, r);              // pad 5 during transfer
            exp_cfg[5] = 13'h0ABC;
            bus_acc(0, 8'h38, 0, r);
            chk(r == 32'h0ABC, "R9 mid write readback", TOTAL'(r), TOTAL'(32'h0ABC));
            bus_acc(1, 8'h00, 32'h1, r);                 // R10 restart attempt
        end
        r = 32'h1;
        while (r == 32'h1) bus_acc(0, 8'h00, 0, r);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [31:0] r;
        logic [TOTAL-1:0] snap;
        for (int p = 0; p < NPADS; p++) exp_cfg[p] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(pad_data == '0 && !chain_shift && !chain_data && !chain_load,
            "R1 outputs", TOTAL'(pad_data), '0);
        bus_acc(0, 8'h24, 0, r); chk(r == 0, "R1 pad0", TOTAL'(r), '0);
        bus_acc(0, 8'hB8, 0, r); chk(r == 0, "R1 pad37", TOTAL'(r), '0);
        bus_acc(0, 8'h00, 0, r); chk(r == 0, "R1 xfer", TOTAL'(r), '0);

        // Table of register vectors
        for (int i = 0; i < 9; i++) begin
            logic [7:0] a;
            logic [31:0] d, e;
            {a, d, e} = VEC[i];
            bus_acc(1, a, d, r);
            if (a >= 8'h24 && a <= 8'hB8 && a[1:0] == 2'b00)
                exp_cfg[(a - 8'h24) >> 2] = d[CFGW-1:0];
            bus_acc(0, a, 0, r);
            chk(r == e, "R3/R4/R5 vector", TOTAL'(r), TOTAL'(e));
        end
        chk(pad_data == {6'h3F, 32'hA5A5_5A5A}, "R4 pad_data",
            TOTAL'(pad_data), TOTAL'({6'h3F, 32'hA5A5_5A5A}));
        chk(ack_ok, "R2 ack timing", TOTAL'(ack_ok), TOTAL'(1));
        chk(ncap == 0, "R5 no transfer from unmapped write", TOTAL'(ncap), '0);

        // R4 timing: data visible right after the write acknowledge
        @(negedge clk);
        bus_cyc = 1; bus_stb = 1; bus_we = 1; bus_adr = 8'h0C; bus_wdat = 32'h1357_9BDF;
        @(negedge clk);
        chk(pad_data[31:0] == 32'h1357_9BDF, "R4 same cycle as ack",
            TOTAL'(pad_data), TOTAL'(32'h1357_9BDF));
        bus_cyc = 0; bus_stb = 0; bus_we = 0;

        // First transfer, with a config write and a restart attempt during it
        run_xfer(1'b1, snap);
        bus_acc(0, 8'h00, 0, r);
        chk(r == 0, "R6 busy clears", TOTAL'(r), '0);
        chk(ncap == TOTAL, "R7 R10 shift count", TOTAL'(ncap), TOTAL'(TOTAL));
        chk(cap == snap, "R7 R9 stream order and snapshot", cap, snap);
        chk(nload == 1 && load_pos_ok, "R8 load pulse", TOTAL'(nload), TOTAL'(1));

        // Second transfer carries the value written during the first
        run_xfer(1'b0, snap);
        chk(cap == snap && snap[5*CFGW +: CFGW] == 13'h0ABC, "R9 new value sent", cap, snap);
        chk(ncap == TOTAL && nload == 1, "R7 R8 second transfer", TOTAL'(ncap), TOTAL'(TOTAL));

        // Writing 0 to the transfer register starts nothing
        ncap = 0;
        bus_acc(1, 8'h00, 32'h0, r);
        repeat (4) @(negedge clk);
        chk(ncap == 0 && !chain_shift, "R6 write 0 ignored", TOTAL'(ncap), '0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule